// File: doc/BRIEF.md
# Low-pin-count bus target with cycle-type filter and capture port

This block is a target on a 4-bit multiplexed low-pin-count bus. It follows every bus cycle nibble by nibble with a state machine that runs in step with the host. Cycles of the two short-address types (a read and a write with a 16-bit address and one data byte) are logged. At the end of such a cycle the address, the data byte and a direction flag appear together on a 32-bit capture word, marked by a one-clock ready pulse. For a logged read the block answers the host with a ready sync nibble, a fixed data byte and a turnaround.

Every other cycle type, such as a memory cycle, is marked as skipped when its type nibble is decoded. The state machine still walks through that cycle's address, turnaround, sync and data phases so that it stays in step with the framing. A skipped cycle never drives the bus, never pulses ready and never changes the capture word. A low frame strobe in any state abandons the cycle in progress. A low bus reset returns the block to idle.

Top module: `lpc_tgt_filter`

## Requirements
- R1: While `rst_n` is low, or in the first clock after it rises, `state_code` is 0 (idle), `lad_oe` and `cap_ready` are 0 and `cap_word` is 0. A low `rst_n` in the middle of a cycle abandons that cycle at once.
- R2: In idle, a clock edge with `frame_n` low and `lad_in` = 0000b moves the block to the start state (`state_code` 1). Further edges with `frame_n` low and `lad_in` = 0000b keep it there. An edge with `frame_n` low and any other nibble goes to, or stays in, idle (0). The other `state_code` values are: 2 address, 3 write data, 4 host turnaround, 5 sync, 6 read data, 7 target turnaround.
- R3: The nibble on the first edge with `frame_n` high after start is the cycle type. 0000b is a logged read and 0010b is a logged write. For any other type, bit 2 set selects 8 address nibbles (otherwise 4), and bit 1 set selects the write phase order (otherwise the read order).
- R4: In a logged write the host sends 4 address nibbles, most significant first, then the data byte, low nibble first. Then come 2 host turnaround clocks, 1 sync clock and 2 target turnaround clocks. In the clock after the last of these, `cap_ready` is 1 and `cap_word` = {address[15:0], data[7:0], 7'b0, 1'b1}.
- R5: In a logged read, the 4 address nibbles are followed by 2 host turnaround clocks. The block then drives `lad_out` with `lad_oe` high: 0000b for one clock, then RD_BYTE low nibble, then high nibble, then 1111b. In the next clock it releases the bus. In the clock after that, `cap_ready` is 1 and `cap_word` = {address, RD_BYTE, 7'b0, 1'b0}.
- R6: In a skipped cycle, `lad_oe` stays 0 in every phase, `cap_ready` stays 0 and `cap_word` keeps its value. The block is back in idle in the clock after the cycle's final turnaround nibble.
- R7: `lad_oe` is 0 in every clock in which `frame_n` is low.
- R8: `frame_n` low in any state past start abandons the cycle without logging it. The block goes to start if `lad_in` = 0000b and to idle otherwise.
- R9: `cap_ready` is never high for two clocks in a row, and `cap_word` changes only in a clock where `cap_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus reset, active low, asynchronous |
| frame_n | input | 1 | Cycle framing strobe, active low |
| lad_in | input | 4 | Nibble sampled from the bus |
| lad_out | output | 4 | Nibble driven onto the bus when enabled |
| lad_oe | output | 1 | Bus drive enable |
| cap_word | output | 32 | Address, data and direction of the last logged cycle |
| cap_ready | output | 1 | One-clock pulse marking a new capture word |
| state_code | output | 4 | Current cycle phase, encoded as in R2 |

## Verification
A wrong type decode or a stale skip flag shows at the ports within the same cycle. It appears as a drive enable in the sync clock of a cycle that should be silent, or as a ready pulse or changed capture word one clock after that cycle's final turnaround. A mistake in the address-length or phase-order choice moves the sync and turnaround clocks, so the drive enable or the return to idle in `state_code` lands a clock or more off the expected slot. A lost abort leaves `state_code` outside idle or start in the clock after the low frame strobe.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

  typedef enum logic [3:0] {
    PH_IDLE  = 4'd0,
    PH_START = 4'd1,
    PH_ADDR  = 4'd2,
    PH_WDATA = 4'd3,
    PH_HTAR  = 4'd4,
    PH_SYNC  = 4'd5,
    PH_RDATA = 4'd6,
    PH_PTAR  = 4'd7
  } phase_t;

  localparam logic [3:0] NIB_START   = 4'h0;
  localparam logic [3:0] TYPE_RD     = 4'h0;
  localparam logic [3:0] TYPE_WR     = 4'h2;
  localparam logic [3:0] NIB_SYNC_OK = 4'h0;
  localparam logic [3:0] NIB_TAR     = 4'hF;

  // Only the two short-address types are logged and answered.
  function automatic logic type_logged(input logic [3:0] t);
    return (t == TYPE_RD) || (t == TYPE_WR);
  endfunction

  function automatic logic type_is_write(input logic [3:0] t);
    return t[1];
  endfunction

  function automatic logic type_wide_addr(input logic [3:0] t);
    return t[2];
  endfunction

endpackage

// File: rtl/lpc_tgt_fsm.sv
module lpc_tgt_fsm
  import lpc_tgt_pkg::*;
#(
  parameter int NARROW_NIB = 4,
  parameter int WIDE_NIB   = 8,
  localparam int CNT_W     = $clog2(WIDE_NIB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic [3:0]       lad_in,
  output phase_t           phase,
  output logic [CNT_W-1:0] cnt,
  output logic             skip,
  output logic             wr,
  output logic             ev_done
);

  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(NARROW_NIB - 1);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(WIDE_NIB - 1);
  localparam logic [CNT_W-1:0] ONE         = CNT_W'(1);

  phase_t           ph_n;
  logic [CNT_W-1:0] cnt_n;
  logic             skip_n, wr_n, wide, wide_n;
  logic [CNT_W-1:0] addr_last;

  assign addr_last = wide ? LAST_WIDE : LAST_NARROW;
  assign ev_done   = frame_n && (phase == PH_PTAR) && (cnt == ONE);

  always_comb begin
    ph_n   = phase;
    cnt_n  = cnt;
    skip_n = skip;
    wr_n   = wr;
    wide_n = wide;
    if (!frame_n) begin
      // Framing strobe wins in every state: start detect or abandon.
      ph_n   = (lad_in == NIB_START) ? PH_START : PH_IDLE;
      cnt_n  = '0;
      skip_n = 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: skip_n = 1'b0;
        PH_START: begin
          ph_n   = PH_ADDR;
          cnt_n  = '0;
          skip_n = !type_logged(lad_in);
          wr_n   = type_is_write(lad_in);
          wide_n = type_wide_addr(lad_in);
        end
        PH_ADDR: begin
          if (cnt == addr_last) begin
            ph_n  = wr ? PH_WDATA : PH_HTAR;
            cnt_n = '0;
          end else cnt_n = cnt + ONE;
        end
        PH_WDATA, PH_HTAR, PH_RDATA, PH_PTAR: begin
          if (cnt == ONE) begin
            cnt_n = '0;
            unique case (phase)
              PH_WDATA: ph_n = PH_HTAR;
              PH_HTAR:  ph_n = PH_SYNC;
              PH_RDATA: ph_n = PH_PTAR;
              default:  ph_n = PH_IDLE;
            endcase
          end else cnt_n = cnt + ONE;
        end
        PH_SYNC: begin
          ph_n  = wr ? PH_PTAR : PH_RDATA;
          cnt_n = '0;
        end
        default: ph_n = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      skip  <= 1'b0;
      wr    <= 1'b0;
      wide  <= 1'b0;
    end else begin
      phase <= ph_n;
      cnt   <= cnt_n;
      skip  <= skip_n;
      wr    <= wr_n;
      wide  <= wide_n;
    end
  end

endmodule

// File: rtl/lpc_tgt_capture.sv
module lpc_tgt_capture
  import lpc_tgt_pkg::*;
#(
  parameter int         ADDR_NIB = 4,
  parameter int         CNT_W    = 3,
  parameter logic [7:0] RD_BYTE  = 8'hA5,
  localparam int        ADDR_W   = ADDR_NIB * 4,
  localparam int        WORD_W   = ADDR_W + 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        lad_in,
  input  phase_t            phase,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              skip,
  input  logic              wr,
  input  logic              ev_done,
  output logic [WORD_W-1:0] cap_word,
  output logic              cap_ready
);

  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;
  logic              ev_log;

  function automatic logic [WORD_W-1:0] pack_word(input logic [ADDR_W-1:0] a,
                                                  input logic [7:0] d,
                                                  input logic w);
    return {a, d, 7'b0, w};
  endfunction

  assign ev_log = ev_done && !skip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      wdata_q   <= '0;
      cap_word  <= '0;
      cap_ready <= 1'b0;
    end else begin
      if (frame_n && !skip && phase == PH_ADDR)
        addr_q <= {addr_q[ADDR_W-5:0], lad_in};
      if (frame_n && !skip && phase == PH_WDATA) begin
        if (cnt == '0) wdata_q[3:0] <= lad_in;
        else           wdata_q[7:4] <= lad_in;
      end
      cap_ready <= ev_log;
      if (ev_log)
        cap_word <= pack_word(addr_q, wr ? wdata_q : RD_BYTE, wr);
    end
  end

endmodule

// File: rtl/lpc_tgt_drive.sv
module lpc_tgt_drive
  import lpc_tgt_pkg::*;
#(
  parameter int         CNT_W   = 3,
  parameter logic [7:0] RD_BYTE = 8'hA5
) (
  input  logic             frame_n,
  input  phase_t           phase,
  input  logic [CNT_W-1:0] cnt,
  input  logic             skip,
  output logic [3:0]       lad_out,
  output logic             lad_oe
);

  logic own_phase;

  always_comb begin
    own_phase = 1'b0;
    lad_out   = 4'h0;
    unique case (phase)
      PH_SYNC:  begin own_phase = 1'b1; lad_out = NIB_SYNC_OK; end
      PH_RDATA: begin
        own_phase = 1'b1;
        lad_out   = (cnt == '0) ? RD_BYTE[3:0] : RD_BYTE[7:4];
      end
      PH_PTAR:  begin own_phase = (cnt == '0); lad_out = NIB_TAR; end
      default:  ;
    endcase
  end

  // Skipped cycles and a low framing strobe both keep the bus released.
  assign lad_oe = own_phase && frame_n && !skip;

endmodule

// File: rtl/lpc_tgt_filter.sv
module lpc_tgt_filter
  import lpc_tgt_pkg::*;
#(
  parameter int         NARROW_NIB = 4,
  parameter int         WIDE_NIB   = 8,
  parameter logic [7:0] RD_BYTE    = 8'hA5,
  localparam int        CNT_W      = $clog2(WIDE_NIB),
  localparam int        WORD_W     = NARROW_NIB * 4 + 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        lad_in,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  output logic [WORD_W-1:0] cap_word,
  output logic              cap_ready,
  output logic [3:0]        state_code
);

  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             skip_q, wr_q, ev_done;

  lpc_tgt_fsm #(.NARROW_NIB(NARROW_NIB), .WIDE_NIB(WIDE_NIB)) u_fsm (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
    .phase(phase_q), .cnt(cnt_q), .skip(skip_q), .wr(wr_q), .ev_done(ev_done)
  );

  lpc_tgt_capture #(.ADDR_NIB(NARROW_NIB), .CNT_W(CNT_W), .RD_BYTE(RD_BYTE)) u_cap (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
    .phase(phase_q), .cnt(cnt_q), .skip(skip_q), .wr(wr_q), .ev_done(ev_done),
    .cap_word(cap_word), .cap_ready(cap_ready)
  );

  lpc_tgt_drive #(.CNT_W(CNT_W), .RD_BYTE(RD_BYTE)) u_drv (
    .frame_n(frame_n), .phase(phase_q), .cnt(cnt_q), .skip(skip_q),
    .lad_out(lad_out), .lad_oe(lad_oe)
  );

  assign state_code = phase_q;

endmodule

// File: rtl/lpc_tgt_filter_chk.sv
module lpc_tgt_filter_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_n,
  input logic [3:0]        lad_in,
  input logic              lad_oe,
  input logic [WORD_W-1:0] cap_word,
  input logic              cap_ready,
  input logic [3:0]        state_code,
  input logic              skip
);

  a_r7_oe_low_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |-> !lad_oe);

  a_r6_skip_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> !lad_oe);

  a_r6_ready_needs_logged: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ready |-> ($past(state_code) == 4'd7 && !$past(skip)));

  a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ready |=> !cap_ready);

  a_r9_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_ready |-> $stable(cap_word));

  a_r2_start_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 4'd0 && !frame_n && lad_in == 4'h0) |=> state_code == 4'd1);

  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code >= 4'd2 && !frame_n) |=> state_code <= 4'd1);

  a_r5_oe_only_owned: assert property (@(posedge clk) disable iff (!rst_n)
    lad_oe |-> (state_code == 4'd5 || state_code == 4'd6 || state_code == 4'd7));

endmodule

bind lpc_tgt_filter lpc_tgt_filter_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
  .lad_oe(lad_oe), .cap_word(cap_word), .cap_ready(cap_ready),
  .state_code(state_code), .skip(skip_q)
);

// File: tb/sim_lpc_tgt_filter.sv
module sim_lpc_tgt_filter;

  localparam logic [7:0] BENCH_RD = 8'h3C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  lad_in = 4'hF;
  logic [3:0]  lad_out;
  logic        lad_oe, cap_ready;
  logic [31:0] cap_word;
  logic [3:0]  state_code;

  int n_vec = 0, n_bad = 0;
  logic [31:0] exp_word = '0;

  always #10 clk = ~clk;

  lpc_tgt_filter #(.RD_BYTE(BENCH_RD)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .cap_word(cap_word),
    .cap_ready(cap_ready), .state_code(state_code)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One bus clock: drive at the falling edge, sample 1 ns later.
  task automatic nib(input logic f, input logic [3:0] d);
    @(negedge clk);
    frame_n = f;
    lad_in  = d;
    #1;
  endtask

  function automatic logic is_logged(input logic [3:0] t);
    return t == 4'h0 || t == 4'h2;
  endfunction

  task automatic run_cycle(input logic [3:0] typ, input logic [15:0] addr,
                           input logic [7:0] wd, input int extra_starts,
                           input bit do_abort, input logic [3:0] abort_nib);
    logic lg, w;
    int alen, len, s, t, ab;
    lg   = is_logged(typ);
    w    = typ[1];
    alen = typ[2] ? 8 : 4;
    len  = 9 + alen;
    s    = 4 + alen + (w ? 2 : 0);
    t    = w ? s + 1 : s + 3;
    ab   = do_abort ? int'($urandom_range(2, len - 2)) : -1;
    for (int k = 0; k < extra_starts; k++) nib(1'b0, 4'h0);
    for (int p = 0; p < len; p++) begin
      logic f;
      logic [3:0] d;
      logic eo;
      logic [3:0] ed;
      if (p == ab) begin
        nib(1'b0, abort_nib);
        chk("R7", "oe with frame low", {31'b0, lad_oe}, 32'd0);
        if (abort_nib == 4'h0) begin
          nib(1'b0, 4'hF);
          chk("R8", "state after abort to start", {28'b0, state_code}, 32'd1);
        end
        nib(1'b1, 4'hF);
        chk("R8", "state after abort", {28'b0, state_code}, 32'd0);
        chk("R8", "no ready after abort", {31'b0, cap_ready}, 32'd0);
        chk("R8", "word after abort", cap_word, exp_word);
        return;
      end
      f = 1'b1;
      d = 4'hF;
      if (p == 0) begin f = 1'b0; d = 4'h0; end
      else if (p == 1) d = typ;
      else if (p < 2 + alen)
        d = (alen == 4) ? addr[(5 - p) * 4 +: 4] : 4'($urandom_range(0, 15));
      else if (w && p == 2 + alen) d = wd[3:0];
      else if (w && p == 3 + alen) d = wd[7:4];
      nib(f, d);
      eo = 1'b0;
      ed = 4'h0;
      if (lg) begin
        if (p == s) eo = 1'b1;
        if (!w && p == s + 1) begin eo = 1'b1; ed = BENCH_RD[3:0]; end
        if (!w && p == s + 2) begin eo = 1'b1; ed = BENCH_RD[7:4]; end
        if (p == t) begin eo = 1'b1; ed = 4'hF; end
      end
      chk(lg ? (w ? "R4" : "R5") : "R6", "drive enable", {31'b0, lad_oe}, {31'b0, eo});
      if (eo) chk(w ? "R4" : "R5", "driven nibble", {28'b0, lad_out}, {28'b0, ed});
      if (p == 1) chk("R2", "start state", {28'b0, state_code}, 32'd1);
      if (p == 2) chk("R3", "address phase", {28'b0, state_code}, 32'd2);
    end
    nib(1'b1, 4'hF);
    if (lg) begin
      exp_word = {addr, w ? wd : BENCH_RD, 7'b0, w};
      chk(w ? "R4" : "R5", "ready", {31'b0, cap_ready}, 32'd1);
      chk(w ? "R4" : "R5", "capture word", cap_word, exp_word);
    end else begin
      chk("R6", "no ready", {31'b0, cap_ready}, 32'd0);
      chk("R6", "word kept", cap_word, exp_word);
    end
    chk(lg ? "R3" : "R6", "idle after cycle", {28'b0, state_code}, 32'd0);
    nib(1'b1, 4'hF);
    chk("R9", "ready one clock", {31'b0, cap_ready}, 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset state", {28'b0, state_code}, 32'd0);
    chk("R1", "reset oe", {31'b0, lad_oe}, 32'd0);
    chk("R1", "reset ready", {31'b0, cap_ready}, 32'd0);
    chk("R1", "reset word", cap_word, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    nib(1'b1, 4'hF);
    chk("R1", "idle after release", {28'b0, state_code}, 32'd0);

    // R2: frame low with a non-start nibble keeps idle
    nib(1'b0, 4'h5);
    nib(1'b0, 4'h9);
    nib(1'b1, 4'hF);
    chk("R2", "noise keeps idle", {28'b0, state_code}, 32'd0);

    // Directed cycles
    run_cycle(4'h2, 16'h1234, 8'h5A, 0, 1'b0, 4'h0);
    run_cycle(4'h0, 16'hBEEF, 8'h00, 0, 1'b0, 4'h0);
    run_cycle(4'h6, 16'h0000, 8'h77, 0, 1'b0, 4'h0);
    run_cycle(4'h4, 16'h0000, 8'h00, 0, 1'b0, 4'h0);
    run_cycle(4'h0, 16'h00FF, 8'h00, 3, 1'b0, 4'h0);
    run_cycle(4'h1, 16'h0000, 8'h00, 0, 1'b0, 4'h0);
    run_cycle(4'hE, 16'h0000, 8'h00, 0, 1'b0, 4'h0);
    run_cycle(4'h2, 16'hFFFF, 8'hFF, 0, 1'b1, 4'h0);
    run_cycle(4'h0, 16'hA001, 8'h00, 0, 1'b1, 4'h7);
    run_cycle(4'h2, 16'h0F0F, 8'hC3, 1, 1'b0, 4'h0);

    // R1: reset in the middle of a cycle
    nib(1'b0, 4'h0);
    nib(1'b1, 4'h2);
    nib(1'b1, 4'h4);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    exp_word = '0;
    chk("R1", "mid-cycle reset state", {28'b0, state_code}, 32'd0);
    chk("R1", "mid-cycle reset word", cap_word, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    nib(1'b1, 4'hF);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int r;
      logic [3:0] typ;
      r = int'($urandom_range(0, 9));
      if (r < 3)       typ = 4'h0;
      else if (r < 6)  typ = 4'h2;
      else if (r == 6) typ = 4'h4;
      else if (r == 7) typ = 4'h6;
      else             typ = 4'($urandom_range(0, 15));
      run_cycle(typ, 16'($urandom()), 8'($urandom()),
                int'($urandom_range(0, 2)), ($urandom_range(0, 7) == 0),
                ($urandom_range(0, 1) == 0) ? 4'h0 : 4'($urandom_range(1, 15)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule